// File: doc/BRIEF.md
# UDMA Operation Control and Status Unit

This block is the operation and status corner of an IDE host controller's Ultra-DMA path. Software reaches it through a small word-addressed register port. It holds a configuration byte, which selects the transfer type and the mode number, and a two-bit operation register, which holds the enable and the transfer direction. Enabling is guarded by a three-step arming handshake. First the direction is written with enable clear. Then the operation register is read back. Then a write sets enable. An enable write that arrives outside this order changes nothing.

A write that clears enable while a transfer is running stops it. The stop clears the whole operation register and sends a one-cycle request to the neighbouring control logic, which then parks both chip selects and both strobes high. The block also reduces the raw flags from the UDMA engine and the device interrupt pin to one two-bit result code, using a fixed priority: error, then interrupt, then active, then idle. The interrupt pin is asynchronous and passes through a synchronizer first.

The arming tracker is a four-state machine:
- `ARM_IDLE` moves to `ARM_DIR_SET` on a direction write.
- `ARM_DIR_SET` moves to `ARM_READ_SEEN` on a read of the operation register. It falls back to `ARM_IDLE` on an early enable write or on a write to any other register.
- `ARM_READ_SEEN` moves to `ARM_RUNNING` on a matching enable write. It returns to `ARM_DIR_SET` on a new direction write. It falls back to `ARM_IDLE` on a mismatched enable write or on a write to another register.
- `ARM_RUNNING` moves to `ARM_IDLE` on a stop write.

Top module: `udma_opstat`

## Requirements
- R1: After reset, `op_enable`, `op_dir`, `ctrl_idle_req`, `dma_result`, `reg_rdata` and all configuration outputs are zero.
- R2: The operation register sits at word offset 3. It reads as bit 0 = enable and bit 1 = direction (1 = host to device), with every other bit zero.
- R3: Three steps arm the enable, in this order: a write with bit 0 clear and the chosen direction, then a read of offset 3, then a write with bit 0 set and the same direction. After that last write `op_enable` is 1 in the next cycle.
- R4: An enable write is ignored and sends the tracker back to its first step in three cases: from the first step, before the read-back step, or with a direction different from the one written in the first step. In each case the register keeps its prior value.
- R5: During arming, a write to any other offset sends the tracker back to its first step. Reads of other offsets leave the tracker where it is.
- R6: While enabled, a write to offset 3 with bit 0 clear clears both bits. It also raises `ctrl_idle_req` for exactly one cycle.
- R7: While enabled, a write to offset 3 with bit 0 set changes neither bit.
- R8: The status register at word offset 10 returns the engine flags at bits 16 (DMA request), 17 (error interrupt), 18 (busy), 24 (data-out incomplete), 25 (data-in incomplete) and 26 (count not a multiple of four words). All other bits read zero.
- R9: `dma_result` is ERROR (3) if bit 17, 24, 25 or 26 is set. Otherwise it is INTERRUPT (2) if the interrupt pin is high. Otherwise it is ACTIVE (1) if bit 16 or 18 is set. Otherwise it is IDLE (0). It follows the flags one cycle later and the pin SYNC_STAGES+1 cycles later.
- R10: The configuration byte sits at word offset 1 and reads back as written: bit 0 enable, bits 1/2/3 select PIO/MDMA/UDMA, bits 7:4 mode. It drives `cfg_enable`, `cfg_xfer_sel` and `cfg_mode`.
- R11: Read data is registered and appears in the cycle after the read strobe. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| eng_status | input | 32 | Raw UDMA engine flags |
| dev_intrq | input | 1 | Device interrupt pin (asynchronous) |
| op_enable | output | 1 | UDMA enable |
| op_dir | output | 1 | Direction, 1 = host to device |
| dma_result | output | 2 | Reduced result code |
| ctrl_idle_req | output | 1 | One-cycle request to park control lines idle |
| cfg_enable | output | 1 | Configuration enable bit |
| cfg_xfer_sel | output | 3 | PIO/MDMA/UDMA select bits |
| cfg_mode | output | 4 | Transfer mode number |

## Verification
The assertions assume that a read strobe and a write strobe never occur in the same cycle. The stimulus always issues one register access at a time, with an idle cycle between accesses, so this holds. They also assume that the engine flags are synchronous to `clk`. The stimulus changes the flags and the interrupt pin only between edges and holds them until the result has settled.

// File: rtl/udma_opstat_pkg.sv
package udma_opstat_pkg;

    typedef enum logic [1:0] {
        ARM_IDLE      = 2'd0,
        ARM_DIR_SET   = 2'd1,
        ARM_READ_SEEN = 2'd2,
        ARM_RUNNING   = 2'd3
    } arm_state_t;

    typedef enum logic [1:0] {
        RES_IDLE   = 2'd0,
        RES_ACTIVE = 2'd1,
        RES_INTR   = 2'd2,
        RES_ERROR  = 2'd3
    } dma_result_t;

    localparam int STS_DMAREQ = 16;
    localparam int STS_ERRINT = 17;
    localparam int STS_BUSY   = 18;
    localparam int STS_NDO    = 24;
    localparam int STS_NDI    = 25;
    localparam int STS_N4X    = 26;

    localparam logic [31:0] STS_MASK = (32'd1 << STS_DMAREQ) | (32'd1 << STS_ERRINT)
                                     | (32'd1 << STS_BUSY)   | (32'd1 << STS_NDO)
                                     | (32'd1 << STS_NDI)    | (32'd1 << STS_N4X);

    localparam int OP_EN_BIT  = 0;
    localparam int OP_DIR_BIT = 1;

endpackage

// File: rtl/udma_sync.sv
module udma_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/udma_arm_fsm.sv
module udma_arm_fsm
    import udma_opstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_wr_i,
    input  logic op_rd_i,
    input  logic other_wr_i,
    input  logic wr_en_bit_i,
    input  logic wr_dir_bit_i,
    output logic op_en_o,
    output logic op_dir_o,
    output logic idle_req_o
);
    arm_state_t state, state_nx;
    logic       dir_q, dir_nx;
    logic       idle_q, idle_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ARM_IDLE;
            dir_q  <= 1'b0;
            idle_q <= 1'b0;
        end else begin
            state  <= state_nx;
            dir_q  <= dir_nx;
            idle_q <= idle_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        dir_nx   = dir_q;
        idle_nx  = 1'b0;
        unique case (state)
            ARM_IDLE: begin
                if (op_wr_i && !wr_en_bit_i) begin
                    state_nx = ARM_DIR_SET;
                    dir_nx   = wr_dir_bit_i;
                end
            end
            ARM_DIR_SET: begin
                if (op_wr_i) begin
                    if (!wr_en_bit_i) dir_nx   = wr_dir_bit_i;
                    else              state_nx = ARM_IDLE;
                end else if (other_wr_i) begin
                    state_nx = ARM_IDLE;
                end else if (op_rd_i) begin
                    state_nx = ARM_READ_SEEN;
                end
            end
            ARM_READ_SEEN: begin
                if (op_wr_i) begin
                    if (!wr_en_bit_i) begin
                        state_nx = ARM_DIR_SET;
                        dir_nx   = wr_dir_bit_i;
                    end else if (wr_dir_bit_i == dir_q) begin
                        state_nx = ARM_RUNNING;
                    end else begin
                        state_nx = ARM_IDLE;
                    end
                end else if (other_wr_i) begin
                    state_nx = ARM_IDLE;
                end
            end
            ARM_RUNNING: begin
                if (op_wr_i && !wr_en_bit_i) begin
                    state_nx = ARM_IDLE;
                    dir_nx   = 1'b0;
                    idle_nx  = 1'b1;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        op_en_o    = (state == ARM_RUNNING);
        op_dir_o   = dir_q;
        idle_req_o = idle_q;
    end

    AST_EN_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_en_o) |-> $past(op_wr_i && wr_en_bit_i && state == ARM_READ_SEEN)); // R3
    AST_RUN_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en_o && $past(op_en_o)) |-> $stable(op_dir_o)); // R7
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en_o && op_wr_i && !wr_en_bit_i) |=> (!op_en_o && !op_dir_o && idle_req_o)); // R6
    AST_IDLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        idle_req_o |=> !idle_req_o); // R6
    AST_OTHER_WR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_en_o && other_wr_i && !op_wr_i) |=> !op_en_o); // R5
endmodule

// File: rtl/udma_result_enc.sv
module udma_result_enc
    import udma_opstat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] sts_i,
    input  logic        irq_i,
    output logic [1:0]  res_o
);
    logic        err_any;
    logic        act_any;
    dma_result_t res_nx, res_q;

    always_comb begin
        err_any = sts_i[STS_ERRINT] | sts_i[STS_NDO] | sts_i[STS_NDI] | sts_i[STS_N4X];
        act_any = sts_i[STS_BUSY] | sts_i[STS_DMAREQ];
        if (err_any)      res_nx = RES_ERROR;
        else if (irq_i)   res_nx = RES_INTR;
        else if (act_any) res_nx = RES_ACTIVE;
        else              res_nx = RES_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= RES_IDLE;
        else        res_q <= res_nx;
    end

    assign res_o = res_q;

    AST_ERROR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_i[STS_N4X] || sts_i[STS_NDI] || sts_i[STS_NDO] || sts_i[STS_ERRINT])
        |=> (res_o == 2'd3)); // R9
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_i & STS_MASK) == 32'd0 && !irq_i) |=> (res_o == 2'd0)); // R9
    AST_IRQ_OVER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_i & STS_MASK) == (32'd1 << STS_BUSY) && irq_i) |=> (res_o == 2'd2)); // R9
endmodule

// File: rtl/udma_opstat.sv
module udma_opstat
    import udma_opstat_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int OFS_CFG     = 1,
    parameter int OFS_OP      = 3,
    parameter int OFS_STS     = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       eng_status,
    input  logic              dev_intrq,
    output logic              op_enable,
    output logic              op_dir,
    output logic [1:0]        dma_result,
    output logic              ctrl_idle_req,
    output logic              cfg_enable,
    output logic [2:0]        cfg_xfer_sel,
    output logic [3:0]        cfg_mode
);
    localparam int CFG_W = 8;
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_OP  = ADDR_W'(OFS_OP);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);

    logic             op_wr, op_rd, other_wr, cfg_wr;
    logic             irq_sync;
    logic [CFG_W-1:0] cfg_q;
    logic [31:0]      rd_mux, rdata_q;

    assign op_wr    = reg_wr && (reg_addr == A_OP);
    assign op_rd    = reg_rd && (reg_addr == A_OP);
    assign other_wr = reg_wr && (reg_addr != A_OP);
    assign cfg_wr   = reg_wr && (reg_addr == A_CFG);

    udma_arm_fsm u_arm (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_wr_i      (op_wr),
        .op_rd_i      (op_rd),
        .other_wr_i   (other_wr),
        .wr_en_bit_i  (reg_wdata[OP_EN_BIT]),
        .wr_dir_bit_i (reg_wdata[OP_DIR_BIT]),
        .op_en_o      (op_enable),
        .op_dir_o     (op_dir),
        .idle_req_o   (ctrl_idle_req)
    );

    udma_sync #(.STAGES(SYNC_STAGES)) u_irq_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (dev_intrq),
        .q_o   (irq_sync)
    );

    udma_result_enc u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .sts_i (eng_status),
        .irq_i (irq_sync),
        .res_o (dma_result)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= reg_wdata[CFG_W-1:0];
    end

    assign cfg_enable   = cfg_q[0];
    assign cfg_xfer_sel = cfg_q[3:1];
    assign cfg_mode     = cfg_q[7:4];

    always_comb begin
        rd_mux = '0;
        if (reg_addr == A_CFG)      rd_mux = {{(32-CFG_W){1'b0}}, cfg_q};
        else if (reg_addr == A_OP)  rd_mux = {30'd0, op_dir, op_enable};
        else if (reg_addr == A_STS) rd_mux = eng_status & STS_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (reg_rd) rdata_q <= rd_mux;
    end

    assign reg_rdata = rdata_q;

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd)); // R11
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr != A_CFG && reg_addr != A_OP && reg_addr != A_STS)
        |=> (reg_rdata == 32'd0)); // R11
    AST_OP_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_OP) |=> (reg_rdata[31:2] == 30'd0)); // R2
endmodule

// File: tb/tb_udma_opstat.sv
module tb_udma_opstat;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata, eng_status = '0;
    logic        dev_intrq = 1'b0;
    logic        op_enable, op_dir, ctrl_idle_req, cfg_enable;
    logic [1:0]  dma_result;
    logic [2:0]  cfg_xfer_sel;
    logic [3:0]  cfg_mode;

    int n_vec = 0, n_bad = 0;
    logic [31:0] rd;

    // bench reference for the arming tracker
    int   m_step = 0;
    logic m_en = 1'b0, m_dir = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    udma_opstat #(.SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_status(eng_status), .dev_intrq(dev_intrq),
        .op_enable(op_enable), .op_dir(op_dir), .dma_result(dma_result),
        .ctrl_idle_req(ctrl_idle_req), .cfg_enable(cfg_enable),
        .cfg_xfer_sel(cfg_xfer_sel), .cfg_mode(cfg_mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_result(input logic [31:0] s, input logic irq);
        if (s[26] || s[25] || s[24] || s[17]) return 2'd3;
        if (irq) return 2'd2;
        if (s[18] || s[16]) return 2'd1;
        return 2'd0;
    endfunction

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        // reference update
        if (a != 4'd3) begin
            if (m_step != 3) m_step = 0;
        end else if (m_step == 3) begin
            if (!d[0]) begin m_step = 0; m_en = 0; m_dir = 0; end
        end else if (!d[0]) begin
            m_step = 1; m_dir = d[1];
        end else if (m_step == 2 && d[1] == m_dir) begin
            m_step = 3; m_en = 1;
        end else begin
            m_step = 0;
        end
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
        if (a == 4'd3 && m_step == 1) m_step = 2;
    endtask

    task automatic chk_op(input string tag);
        chk({tag, " enable"}, {31'd0, op_enable}, {31'd0, m_en});
        chk({tag, " dir"},    {31'd0, op_dir},    {31'd0, m_dir});
    endtask

    task automatic set_flags(input logic [31:0] s, input logic irq);
        @(negedge clk);
        eng_status = s; dev_intrq = irq;
        repeat (SYNC + 2) @(negedge clk);
        chk("R9 result", {30'd0, dma_result}, {30'd0, exp_result(s, irq)});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D3A_5EED));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 enable", {31'd0, op_enable}, 32'd0);
        chk("R1 dir", {31'd0, op_dir}, 32'd0);
        chk("R1 idle_req", {31'd0, ctrl_idle_req}, 32'd0);
        chk("R1 result", {30'd0, dma_result}, 32'd0);
        chk("R1 rdata", reg_rdata, 32'd0);
        chk("R1 cfg", {24'd0, cfg_mode, cfg_xfer_sel, cfg_enable}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R10: configuration byte
        wr_reg(4'd1, 32'h0000_00A9);
        chk("R10 cfg outputs", {24'd0, cfg_mode, cfg_xfer_sel, cfg_enable}, 32'hA9);
        rd_reg(4'd1, rd); chk("R10 cfg readback", rd, 32'hA9);
        wr_reg(4'd1, 32'hFFFF_FF23);
        rd_reg(4'd1, rd); chk("R10 cfg upper bits dropped", rd, 32'h23);

        // R3: correct arming sequence, host-to-device
        wr_reg(4'd3, 32'h2); chk_op("R3 step1");
        rd_reg(4'd3, rd); chk("R2 readback dir", rd, 32'h2);
        wr_reg(4'd3, 32'h3); chk("R3 armed", {31'd0, op_enable}, 32'd1);
        rd_reg(4'd3, rd); chk("R2 readback armed", rd, 32'h3);
        // R7: enable write while running
        wr_reg(4'd3, 32'h1); chk_op("R7 no change");
        // R6: stop
        wr_reg(4'd3, 32'h0);
        chk("R6 idle_req pulse", {31'd0, ctrl_idle_req}, 32'd1);
        chk_op("R6 cleared");
        @(negedge clk);
        chk("R6 idle_req drops", {31'd0, ctrl_idle_req}, 32'd0);

        // R4: out-of-order enables
        wr_reg(4'd3, 32'h1); chk_op("R4 enable from idle");
        wr_reg(4'd3, 32'h2); wr_reg(4'd3, 32'h3); chk_op("R4 enable before read");
        rd_reg(4'd3, rd); wr_reg(4'd3, 32'h3); chk_op("R4 no restart after abort");
        chk("R4 dir held", {31'd0, op_dir}, 32'd1);
        wr_reg(4'd3, 32'h0); rd_reg(4'd3, rd); wr_reg(4'd3, 32'h3); chk_op("R4 dir mismatch");

        // R5: intervening writes and reads
        wr_reg(4'd3, 32'h2); rd_reg(4'd3, rd); wr_reg(4'd1, 32'h11); wr_reg(4'd3, 32'h3);
        chk_op("R5 other write aborts");
        wr_reg(4'd3, 32'h0); rd_reg(4'd10, rd); rd_reg(4'd3, rd); rd_reg(4'd5, rd); wr_reg(4'd3, 32'h1);
        chk("R5 other reads harmless", {31'd0, op_enable}, 32'd1);
        chk_op("R5 device-to-host armed");
        wr_reg(4'd3, 32'h0); chk_op("R6 stop again");

        // R11: unmapped offset
        rd_reg(4'd7, rd); chk("R11 unmapped zero", rd, 32'd0);

        // R8 / R9 directed corners
        eng_status = 32'hFFFF_FFFF;
        rd_reg(4'd10, rd); chk("R8 status mask", rd, 32'h0707_0000);
        set_flags(32'h0002_0000, 1'b1);
        set_flags(32'h0100_0000, 1'b0);
        set_flags(32'h0200_0000, 1'b1);
        set_flags(32'h0400_0000, 1'b0);
        set_flags(32'h0004_0000, 1'b1);
        set_flags(32'h0004_0000, 1'b0);
        set_flags(32'h0001_0000, 1'b0);
        set_flags(32'h00F8_FFFF, 1'b0);
        set_flags(32'h0000_0000, 1'b1);
        set_flags(32'h0000_0000, 1'b0);

        // random flag vectors
        for (int i = 0; i < 200; i++) begin
            logic [31:0] s;
            s = $urandom() & ~32'h0707_0000;
            if ($urandom_range(3) == 0) s[16] = 1'b1;
            if ($urandom_range(5) == 0) s[17] = 1'b1;
            if ($urandom_range(3) == 0) s[18] = 1'b1;
            if ($urandom_range(7) == 0) s[24] = 1'b1;
            if ($urandom_range(7) == 0) s[25] = 1'b1;
            if ($urandom_range(7) == 0) s[26] = 1'b1;
            set_flags(s, 1'($urandom_range(1)));
            if (i % 8 == 0) begin
                rd_reg(4'd10, rd); chk("R8 status random", rd, s & 32'h0707_0000);
            end
        end
        set_flags(32'd0, 1'b0);

        // random register traffic against the reference tracker
        for (int i = 0; i < 400; i++) begin
            int k;
            k = $urandom_range(9);
            if (k < 4) begin
                wr_reg(4'd3, {30'd0, 2'($urandom_range(3))});
                chk_op("R3 random write");
            end else if (k < 7) begin
                logic [1:0] e;
                e = {m_dir, m_en};
                rd_reg(4'd3, rd);
                chk("R2 random readback", rd, {30'd0, e});
            end else if (k == 7) begin
                wr_reg(4'($urandom_range(15) == 3 ? 1 : $urandom_range(15) & 4'hB), $urandom());
                chk_op("R5 random other write");
            end else begin
                rd_reg(4'($urandom_range(15) == 3 ? 10 : 10), rd);
                chk_op("R5 random other read");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule